// File: doc/BRIEF.md
# Packed BCD Digit Shifter

This unit moves a 128-bit operand holding 32 unsigned packed decimal digits by a whole number of digit positions. Digit 0 is the most significant nibble, in bits 127:124, and digit 31 is the least significant nibble. A second 128-bit operand supplies the shift amount as a signed two's-complement byte. A positive amount moves the digits toward digit 0. Zero or a negative amount moves them toward digit 31. Vacated positions always fill with zero digits. The amount is clamped, so a distance past the full digit count leaves the result all zero.

Alongside the shifted value, the unit reports a 4-bit condition word. The word says whether the source operand was zero or nonzero, whether it held a non-decimal nibble, and whether a left move discarded a nonzero digit. The unit has one register stage: operands presented with `valid_i` produce results on the next cycle, and those results are held until the next accepted operation.

Top module: `bcd_digit_shifter`

## Requirements
- R1: After reset is asserted, valid_o, res_o and cond_o are all zero.
- R2: The signed shift amount is taken only from bits 71:64 of cnt_src_i, read as a two's-complement byte. All other bits of cnt_src_i have no effect on the outputs.
- R3: An amount k greater than zero moves each digit at position i+k to position i, counting positions from digit 0 at bits 127:124. The k lowest positions (digits 31 down to 32-k) are filled with zero.
- R4: An amount of zero or less moves each digit at position i to position i+m, where m is the magnitude of the amount. The m highest positions are filled with zero. An amount of zero returns the operand unchanged.
- R5: A magnitude of 33 or more, including -128, acts as a move of 32 digits, so res_o is all zero.
- R6: When any source nibble exceeds 9, res_o is all zero and cond_o is 4'b0001.
- R7: cond_o is {lt, gt, eq, so} with lt in bit 3 and so in bit 0. lt is always 0. For a valid operand, eq (bit 1) is 1 exactly when all 32 source digits are zero, and gt (bit 2) is the inverse of eq. Both flags describe the source operand, not the result.
- R8: so (bit 0) is set for a valid operand only when a left move of nonzero distance discards at least one nonzero digit from the top positions. A move of zero distance or a right move never sets it.
- R9: res_o and cond_o reflect operands sampled on the clock edge where valid_i is high. valid_o is high for exactly the next cycle. While valid_i is low, res_o and cond_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands are presented this cycle |
| val_i | input | 128 | Packed decimal digits, digit 0 in bits 127:124 |
| cnt_src_i | input | 128 | Operand whose bits 71:64 carry the signed shift amount |
| valid_o | output | 1 | Result is fresh this cycle |
| res_o | output | 128 | Shifted digits |
| cond_o | output | 4 | Condition word {lt, gt, eq, so} |

## Verification
Invalid-digit detection and left-shift overflow both drive the so bit, so they can be active in the same cycle. The bench provokes this with a left shift that discards a nonzero top digit while another nibble holds a value of 10 or more. The expected outcome is so set with gt and eq cleared and an all-zero result, which matches the invalid case alone. Clamping also coincides with overflow: an amount of 127 on a nonzero operand has to report overflow and an empty result in the same cycle, and the random mix produces both combinations repeatedly.

// File: rtl/bcd_shift_pkg.sv
package bcd_shift_pkg;
  localparam int unsigned NDIG     = 32;
  localparam int unsigned DIG_W    = 4;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned SEL_BYTE = 7;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/bcd_digit_check.sv
module bcd_digit_check #(
  parameter int unsigned NDIG  = 32,
  parameter int unsigned DIG_W = 4,
  localparam int unsigned VW   = NDIG * DIG_W
) (
  input  logic [VW-1:0] val_i,
  output logic          invalid_o,
  output logic          zero_o
);
  logic [NDIG-1:0] bad;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    assign bad[i] = val_i[i*DIG_W +: DIG_W] > DIG_W'(9);
  end

  assign invalid_o = |bad;
  assign zero_o    = ~|val_i;
endmodule

// File: rtl/bcd_count_decode.sv
module bcd_count_decode #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned NDIG  = 32,
  localparam int unsigned MAG_W = $clog2(NDIG + 1)
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             left_o,
  output logic [MAG_W-1:0] mag_o
);
  logic signed [CNT_W:0] ext;
  logic        [CNT_W:0] magn;

  always_comb begin
    ext    = {cnt_i[CNT_W-1], cnt_i};
    left_o = ext > 0;
    // 9-bit negate keeps -128 as +128
    magn   = left_o ? ext : -ext;
    mag_o  = (magn > (CNT_W+1)'(NDIG)) ? MAG_W'(NDIG) : MAG_W'(magn);
  end
endmodule

// File: rtl/bcd_shift_core.sv
module bcd_shift_core #(
  parameter int unsigned NDIG  = 32,
  parameter int unsigned DIG_W = 4,
  localparam int unsigned VW    = NDIG * DIG_W,
  localparam int unsigned MAG_W = $clog2(NDIG + 1),
  localparam int unsigned SH_W  = MAG_W + $clog2(DIG_W)
) (
  input  logic [VW-1:0]    val_i,
  input  logic             left_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [VW-1:0]    res_o,
  output logic             ovf_o
);
  logic [SH_W-1:0] sh;
  logic [NDIG-1:0] lost;

  assign sh = SH_W'(mag_i) * SH_W'(DIG_W);

  // digit i counted from the most significant end
  for (genvar i = 0; i < NDIG; i++) begin : g_lost
    assign lost[i] = (MAG_W'(i) < mag_i) && (val_i[VW-1-i*DIG_W -: DIG_W] != '0);
  end

  assign res_o = left_i ? (val_i << sh) : (val_i >> sh);
  assign ovf_o = left_i & (|lost);
endmodule

// File: rtl/bcd_digit_shifter.sv
module bcd_digit_shifter
  import bcd_shift_pkg::*;
#(
  parameter int unsigned N_DIG = NDIG,
  parameter int unsigned D_W   = DIG_W,
  localparam int unsigned VW    = N_DIG * D_W,
  localparam int unsigned MAG_W = $clog2(N_DIG + 1),
  localparam int unsigned CNT_LSB = VW - CNT_W * (SEL_BYTE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [VW-1:0] val_i,
  input  logic [VW-1:0] cnt_src_i,
  output logic          valid_o,
  output logic [VW-1:0] res_o,
  output logic [3:0]    cond_o
);
  logic             invalid, zero, left, ovf;
  logic [MAG_W-1:0] mag;
  logic [VW-1:0]    shifted, res_d;
  cond_t            cond_d, cond_q;

  bcd_digit_check #(.NDIG(N_DIG), .DIG_W(D_W)) u_check (
    .val_i     (val_i),
    .invalid_o (invalid),
    .zero_o    (zero)
  );

  bcd_count_decode #(.CNT_W(CNT_W), .NDIG(N_DIG)) u_cnt (
    .cnt_i  (cnt_src_i[CNT_LSB +: CNT_W]),
    .left_o (left),
    .mag_o  (mag)
  );

  bcd_shift_core #(.NDIG(N_DIG), .DIG_W(D_W)) u_core (
    .val_i  (val_i),
    .left_i (left),
    .mag_i  (mag),
    .res_o  (shifted),
    .ovf_o  (ovf)
  );

  always_comb begin
    res_d     = invalid ? '0 : shifted;
    cond_d.lt = 1'b0;
    cond_d.gt = ~invalid & ~zero;
    cond_d.eq = ~invalid & zero;
    cond_d.so = invalid | ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      cond_q  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o  <= res_d;
        cond_q <= cond_d;
      end
    end
  end

  assign cond_o = cond_q;
endmodule

// File: rtl/bcd_digit_shifter_chk.sv
module bcd_digit_shifter_chk #(
  parameter int unsigned VW = 128
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [VW-1:0] cnt_src_i,
  input logic          valid_o,
  input logic [VW-1:0] res_o,
  input logic [3:0]    cond_o
);
  p_lt_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !cond_o[3]);

  p_gt_eq_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(cond_o[2] && cond_o[1]));

  p_eq_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cond_o[1]) |-> (res_o == '0 && !cond_o[0]));

  p_invalid_res_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cond_o[2:1] == 2'b00) |-> (res_o == '0 && cond_o[0]));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $signed(cnt_src_i[71:64]) <= 0) |=> (cond_o[0] == (cond_o[2:1] == 2'b00)));

  p_valid_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(cond_o)));
endmodule

bind bcd_digit_shifter bcd_digit_shifter_chk #(.VW(VW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .cnt_src_i (cnt_src_i),
  .valid_o   (valid_o),
  .res_o     (res_o),
  .cond_o    (cond_o)
);

// File: tb/bcd_digit_shifter_tb.sv
module bcd_digit_shifter_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] val_i = '0;
  logic [127:0] cnt_src_i = '0;
  logic         valid_o;
  logic [127:0] res_o;
  logic [3:0]   cond_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk_i = ~clk_i;

  bcd_digit_shifter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .val_i(val_i),
    .cnt_src_i(cnt_src_i), .valid_o(valid_o), .res_o(res_o), .cond_o(cond_o)
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [3:0] nib(logic [127:0] v, int i);
    return v[127-4*i -: 4];
  endfunction

  // returns {cond, result}
  function automatic logic [131:0] model(logic [127:0] vb, logic [127:0] va);
    int n, mag, src;
    bit left, inv, zero, ovf;
    logic [127:0] r;
    n = int'($signed(va[71:64]));
    left = n > 0;
    mag = left ? n : -n;
    if (mag > 32) mag = 32;
    inv = 0; zero = 1; ovf = 0; r = '0;
    for (int i = 0; i < 32; i++) begin
      if (nib(vb, i) > 9) inv = 1;
      if (nib(vb, i) != 0) zero = 0;
      if (left && i < mag && nib(vb, i) != 0) ovf = 1;
      src = left ? i + mag : i - mag;
      if (src >= 0 && src < 32) r[127-4*i -: 4] = nib(vb, src);
    end
    if (inv) r = '0;
    return {1'b0, !inv && !zero, !inv && zero, inv || ovf, r};
  endfunction

  task automatic check(string req, logic [131:0] act, logic [131:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [127:0] vb, logic [127:0] va);
    logic [131:0] e;
    e = model(vb, va);
    @(negedge clk_i);
    val_i = vb; cnt_src_i = va; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " result"}, {4'b0, res_o}, {4'b0, e[127:0]});
    check({req, " cond"}, {128'b0, cond_o}, {128'b0, e[131:128]});
    check({req, " R9 valid"}, {131'b0, valid_o}, 132'd1);
  endtask

  function automatic logic [127:0] cnt(int n, logic [127:0] filler);
    logic [127:0] v;
    v = filler;
    v[71:64] = 8'(n);
    return v;
  endfunction

  function automatic logic [127:0] rand_bcd(int lead);
    logic [127:0] v;
    for (int i = 0; i < 32; i++)
      v[127-4*i -: 4] = (i < lead) ? 4'd0 : 4'($urandom % 10);
    return v;
  endfunction

  localparam logic [127:0] V1 = 128'h12345678901234567890123456789012;
  localparam logic [127:0] V2 = 128'h00003456789012345678901234567890;

  initial begin
    logic [127:0] vb, va, held;
    logic [3:0] held_c;
    void'($urandom(32'd20240611));
    #1;
    checks++;
    if (valid_o !== 1'b0 || res_o !== '0 || cond_o !== 4'b0) begin
      errors++;
      $display("FAIL R1: actual=%b/%h/%b expected=0/0/0", valid_o, res_o, cond_o);
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    run("R3 left1 ovf", V1, cnt(1, '0));
    run("R8 left4 no ovf", V2, cnt(4, '0));
    run("R8 left5 ovf", V2, cnt(5, '0));
    run("R4 right3", V1, cnt(-3, '0));
    run("R4 zero amount", V1, cnt(0, '0));
    run("R2 other bytes ignored", V1, cnt(0, {128{1'b1}}));
    run("R2 byte7 only", V1, cnt(-2, 128'hA5A5A5A5_A5A5A5A5_A5A5A5A5_A5A5A5A5));
    run("R3 left32", V1, cnt(32, '0));
    run("R5 clamp 33", V1, cnt(33, '0));
    run("R5 clamp 127", V1, cnt(127, '0));
    run("R5 clamp -128", V1, cnt(-128, '0));
    run("R5 right32", V1, cnt(-32, '0));
    run("R6 invalid", 128'h1234567890123456789012345678901F, cnt(-1, '0));
    run("R6 invalid with ovf", 128'h9000000000000000000000000000000B, cnt(3, '0));
    run("R7 zero input", '0, cnt(5, '0));
    run("R8 right no ovf", V1, cnt(-31, '0));

    // R9 hold: idle cycles keep outputs
    held = res_o; held_c = cond_o;
    @(negedge clk_i);
    val_i = ~V1; cnt_src_i = cnt(2, '0);
    @(negedge clk_i);
    check("R9 hold res", {4'b0, res_o}, {4'b0, held});
    check("R9 hold cond", {128'b0, cond_o}, {128'b0, held_c});
    check("R9 valid low", {131'b0, valid_o}, 132'd0);

    for (int k = 0; k < 400; k++) begin
      vb = rand_bcd(($urandom % 4 == 0) ? int'($urandom % 33) : 0);
      if ($urandom % 8 == 0) vb[4*($urandom % 32) +: 4] = 4'(10 + $urandom % 6);
      if ($urandom % 16 == 0) vb = '0;
      va = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom % 4 != 0) va = cnt(int'($urandom % 81) - 40, va);
      run("R3/R4/R8 random", vb, va);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule